// File: doc/BRIEF.md
# Frame-Synchronized Serial Byte Capture

This block sits behind a converter that sends a continuous serial stream and drives its own bit clock. It runs entirely on that bit clock. Incoming bits are shifted in most significant bit first. Every eighth bit completes a byte, which is copied into a holding register that a slower consumer reads at its leisure.

Completed bytes are announced by a ready flag that changes level once per byte. The consumer therefore watches for any edge of the flag, rising or falling, instead of catching a one-cycle pulse. The flag and the holding register change on the same serial clock edge.

A frame-start pulse, sampled on the bit clock, marks the first bit of a frame. It realigns the bit counter so that byte boundaries are always measured from the frame start. Between frame pulses the counter runs freely over a word of two bytes (16 bits) and wraps.

Top module: `serial_byte_capture`

## Requirements
- R1: Bits are taken MSB first. The bit sampled at a byte's first edge appears in `byte_out[7]`, and the bit sampled at its eighth edge appears in `byte_out[0]`.
- R2: `byte_out` takes the new byte on the same rising `sclk` edge that samples the byte's eighth bit. It is visible immediately after that edge.
- R3: On every other edge, `byte_out` keeps its value.
- R4: `byte_ready` inverts exactly once per completed byte, on the same edge as R2, and at no other edge. A high-to-low change and a low-to-high change both mean that a new byte is waiting.
- R5: When `frame_start` is high at an edge, the bit sampled at that edge becomes bit 7 of a new byte. Bits gathered before it that did not complete a byte are dropped, with no update of `byte_out` and no change of `byte_ready`.
- R6: With no `frame_start`, the bit position wraps every 16 bits. Bytes keep completing every 8 bits, and after one word of two bytes `byte_ready` is back at its earlier level.
- R7: When `rst_n` is low at an edge, that edge clears `byte_out` to 0x00 and `byte_ready` to 0, and restarts the bit position. The next 8 bits then form a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock from the converter; rising edge samples data |
| rst_n | input | 1 | Synchronous active-low reset |
| sdata | input | 1 | Serial data bit |
| frame_start | input | 1 | High for the edge that samples the first bit of a frame |
| byte_out | output | 8 | Holding register with the last completed byte |
| byte_ready | output | 1 | Changes level each time a byte completes |

## Verification
A wrong bit position inside the block shows up at the ports within at most eight edges. Either `byte_ready` flips at the wrong edge, or `byte_out` carries a byte shifted by one or more bits. A fault in the shift path shows as a wrong value in the very next completed byte. A broken frame realignment only shows after a frame pulse that arrives away from a byte boundary, so the bench creates that case on purpose.

// File: rtl/sbc_pkg.sv
// Package: shared helpers for the serial byte capture block.
// Assumes: widths passed in are at least 1.
package sbc_pkg;

    // Number of bits needed to index n positions, never below 1.
    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sbc_sipo.sv
// Module: serial-in shift store.
// Keeps the last BYTE_W-1 bits received and presents the byte that the
// current bit would complete. The oldest bit leaves the store on the edge
// that would complete a byte, so a full BYTE_W-bit register is not needed.
// Assumes: BYTE_W >= 2; sdata is stable around the rising clock edge.
module sbc_sipo #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    output logic [BYTE_W-1:0] byte_nxt
);
    logic [BYTE_W-2:0] store_q;

    // Shift one bit in per clock, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= byte_nxt[BYTE_W-2:0];
    end

    // Byte as it would stand if this bit closes it.
    always_comb byte_nxt = {store_q, sdata};
endmodule

// File: rtl/sbc_bit_counter.sv
// Module: frame-aligned bit position counter.
// Counts bits modulo one word and flags the edge that samples the last bit
// of a byte. A frame pulse makes the current edge bit 0 of the frame.
// Assumes: BYTE_W is a power of two; WORD_BYTES >= 1.
module sbc_bit_counter #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic byte_done
);
    localparam int WORD_BITS = BYTE_W * WORD_BYTES;
    localparam int CNT_W     = sbc_pkg::bits_for(WORD_BITS);
    localparam int POS_W     = sbc_pkg::bits_for(BYTE_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos_now;
    logic [CNT_W-1:0] cnt_nxt;

    // Position of the bit sampled at this edge.
    always_comb pos_now = frame_start ? '0 : cnt_q;

    // Next position, wrapping at the end of a word.
    always_comb begin
        if (pos_now == CNT_W'(WORD_BITS - 1)) cnt_nxt = '0;
        else                                  cnt_nxt = pos_now + CNT_W'(1);
    end

    // Last bit of a byte is sampled at this edge.
    always_comb byte_done = (pos_now[POS_W-1:0] == POS_W'(BYTE_W - 1));

    // Register the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/sbc_holding.sv
// Module: byte holding register with toggle-style ready flag.
// Loads a finished byte and inverts the ready flag on the same edge.
// Assumes: load is high for exactly one edge per byte.
module sbc_holding #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_ready
);
    // Hold the byte until the next one completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    byte_out <= '0;
        else if (load) byte_out <= din;
    end

    // Flip the ready level once per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    byte_ready <= 1'b0;
        else if (load) byte_ready <= ~byte_ready;
    end
endmodule

// File: rtl/serial_byte_capture.sv
// Module: frame-synchronized serial byte capture (top).
// Shifts in a serial stream on its own bit clock, latches each completed
// byte and announces it by a level change on byte_ready.
// Assumes: all inputs are synchronous to sclk; reset is synchronous.
module serial_byte_capture #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 2
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              frame_start,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_ready
);
    logic [BYTE_W-1:0] byte_nxt;
    logic              byte_done;

    sbc_sipo #(.BYTE_W(BYTE_W)) u_sipo (
        .clk      (sclk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .byte_nxt (byte_nxt)
    );

    sbc_bit_counter #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_cnt (
        .clk         (sclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .byte_done   (byte_done)
    );

    sbc_holding #(.BYTE_W(BYTE_W)) u_hold (
        .clk        (sclk),
        .rst_n      (rst_n),
        .load       (byte_done),
        .din        (byte_nxt),
        .byte_out   (byte_out),
        .byte_ready (byte_ready)
    );
endmodule

// File: rtl/sbc_checker.sv
// Module: port-level checker for serial_byte_capture.
// Tracks the byte position from the ports alone and checks latching,
// stability and ready toggling against it.
// Assumes: BYTE_W is a power of two.
module sbc_checker #(
    parameter int BYTE_W = 8
) (
    input logic              sclk,
    input logic              rst_n,
    input logic              sdata,
    input logic              frame_start,
    input logic [BYTE_W-1:0] byte_out,
    input logic              byte_ready
);
    localparam int POS_W = sbc_pkg::bits_for(BYTE_W);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_now;
    logic             exp_done;
    logic             first_q;

    // Expected position of the bit sampled at this edge.
    always_comb pos_now  = frame_start ? '0 : pos_q;
    always_comb exp_done = (pos_now == POS_W'(BYTE_W - 1));

    // Independent position tracker.
    always_ff @(posedge sclk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_now + POS_W'(1);
    end

    // Remember the first bit of the byte in progress.
    always_ff @(posedge sclk) begin
        if (!rst_n)             first_q <= 1'b0;
        else if (pos_now == '0) first_q <= sdata;
    end

    p_first_bit_r1: assert property (@(posedge sclk) disable iff (!rst_n)
        exp_done |=> byte_out[BYTE_W-1] == first_q);

    p_last_bit_r2: assert property (@(posedge sclk) disable iff (!rst_n)
        exp_done |=> byte_out[0] == $past(sdata));

    p_hold_stable_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        !exp_done |=> $stable(byte_out));

    p_ready_flip_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        exp_done |=> byte_ready != $past(byte_ready));

    p_ready_quiet_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        !exp_done |=> $stable(byte_ready));

    p_reset_clear_r7: assert property (@(posedge sclk)
        !rst_n |=> (byte_out == '0) && !byte_ready);
endmodule

bind serial_byte_capture sbc_checker #(.BYTE_W(BYTE_W)) u_chk (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .sdata       (sdata),
    .frame_start (frame_start),
    .byte_out    (byte_out),
    .byte_ready  (byte_ready)
);

// File: tb/tb_serial_byte_capture.sv
module tb_serial_byte_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] byte_out;
    logic       byte_ready;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic exp_rdy = 1'b0;

    serial_byte_capture dut (
        .sclk(clk), .rst_n(rst_n), .sdata(sdata),
        .frame_start(frame_start), .byte_out(byte_out), .byte_ready(byte_ready)
    );

    always #10 clk = ~clk;

    // {frame_start on first bit, byte value}
    localparam logic [8:0] VEC [6] = '{
        {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h80},
        {1'b0, 8'h01}, {1'b0, 8'hFF}, {1'b1, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one bit for the next rising edge; return after it (at negedge).
    task automatic step(input logic b, input logic fs);
        sdata = b;
        frame_start = fs;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Send a byte MSB first and check the mid-byte quiet and the result.
    task automatic send_byte(input logic [7:0] d, input logic fs);
        logic [7:0] prev_out;
        prev_out = byte_out;
        for (int i = 7; i >= 0; i--) begin
            step(d[i], fs && (i == 7));
            if (i == 3) begin
                chk("R3 hold mid-byte", byte_out, prev_out);
                chk("R4 ready mid-byte", {7'd0, byte_ready}, {7'd0, exp_rdy});
            end
        end
        exp_rdy = ~exp_rdy;
        chk("R1/R2 byte latched", byte_out, d);
        chk("R4 ready toggled", {7'd0, byte_ready}, {7'd0, exp_rdy});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic lvl;
        @(negedge clk);
        @(negedge clk);
        chk("R7 reset byte_out", byte_out, 8'h00);
        chk("R7 reset ready", {7'd0, byte_ready}, 8'h00);
        rst_n = 1'b1;

        // Vector table walk.
        for (int v = 0; v < 6; v++) send_byte(VEC[v][7:0], VEC[v][8]);

        // R5: partial bits before a frame pulse are dropped.
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R5 no update on partial", byte_out, 8'h00);
        chk("R5 no toggle on partial", {7'd0, byte_ready}, {7'd0, exp_rdy});
        send_byte(8'h5A, 1'b1);

        // R6: word wrap without frame pulses keeps alignment.
        lvl = byte_ready;
        send_byte(8'h96, 1'b0);
        send_byte(8'h69, 1'b0);
        chk("R6 ready level after word", {7'd0, byte_ready}, {7'd0, lvl});
        send_byte(8'hC7, 1'b0);
        chk("R6 third byte aligned", byte_out, 8'hC7);

        // R7: reset in the middle of a byte.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        rst_n = 1'b0;
        step(1'b0, 1'b0);
        rst_n = 1'b1;
        exp_rdy = 1'b0;
        chk("R7 mid-byte reset byte_out", byte_out, 8'h00);
        chk("R7 mid-byte reset ready", {7'd0, byte_ready}, 8'h00);
        send_byte(8'hC3, 1'b0);
        chk("R7 position restarted", byte_out, 8'hC3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule